// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block computes a single-error-correcting Hamming code over a 512-byte NAND page while the page bytes flow past it on a byte stream. The page is split into two independent 256-byte halves. Each half gets its own 16 line-parity bits, built from the byte index, and 6 column-parity bits, built from the bit position inside each byte. Software or a host sequencer first clears the accumulators and then enables accumulation. It moves the page, switches the data register to result mode, and collects the six code bytes with three 16-bit reads.

Control is a four-state machine driven by mode-register writes:

- ST_DATA is the normal data mode and the state after reset.
- Mode 0xF4 moves to ST_CLR_WAIT. In that state each data-register read clears both halves and the byte counter.
- Mode 0xB4 moves to ST_CALC, where valid bytes are accumulated.
- Mode 0xD4 moves to ST_RESULT and rewinds the read pointer. Each read there advances the pointer through three words, then wraps.
- Mode 0x94 returns to ST_DATA from any state.

Any other mode code leaves the state as it is. A mode write takes effect on the next clock. A byte or read presented in the same cycle is handled under the old state.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset the block is in ST_DATA, both halves and the byte counter are zero, and rd_data is 0.
- R2: In ST_CLR_WAIT (entered by mode code 0xF4) a read strobe clears all line parity, column parity and the byte counter; a following result readout of an empty page gives words 0x0000, 0x0003, 0x0300.
- R3: Bytes are accumulated only in ST_CALC (mode code 0xB4) when byte_valid is high; bytes offered in any other state leave all parity unchanged.
- R4: For a byte of odd bit-weight at index i (0..255) within its half, line parity bit 2k+1 toggles when bit k of i is 1 and bit 2k toggles when it is 0 (k = 0..7); bytes of even weight leave line parity unchanged.
- R5: Column parity bit 2k+1 is the XOR of all data bits whose position has bit k set, bit 2k the XOR of those with bit k clear (k = 0..2); the code byte for a half is {CP[5:0], 2'b11}.
- R6: Accepted bytes 0..255 of the page go to the first half and bytes 256..511 to the second half, selected by the byte counter.
- R7: Bytes offered after 512 have been accepted are ignored until the next clear.
- R8: In ST_RESULT (mode code 0xD4) rd_data shows word 0 = {LP0[7:0], LP0[15:8]}, word 1 = {LP1[7:0], code byte 0}, word 2 = {code byte 1, LP1[15:8]} (LP0/LP1 first/second half); each read strobe advances to the next word and word 2 wraps to word 0.
- R9: Mode code 0x94 returns to ST_DATA, where rd_data is 0; unlisted mode codes change nothing.
- R10: Entering ST_CALC from ST_CLR_WAIT without a read strobe keeps the old parity and byte count, and accumulation continues from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_code | input | 8 | Mode code written with mode_wr |
| byte_valid | input | 1 | Page byte present on byte_in |
| byte_in | input | 8 | Page data byte |
| rd_strobe | input | 1 | Data register read strobe |
| rd_data | output | 16 | Result word in ST_RESULT, otherwise 0 |

## Verification
On every cycle, the assertions check the following:

- The byte counter stays within the page.
- Only the first half is written while the counter is below 256.
- A clear empties both halves on the next cycle.
- Idle halves and even-weight bytes leave the parity unchanged.
- The read pointer never leaves its three words.
- The second result word always carries the 11 marker.
- A 0x94 write always lands in ST_DATA.

Only the bench scenarios can show the actual parity values, the interleaved word order, and the wrap after the third read. The same holds for overflow bytes past 512 being dropped and for a missing dummy read leaving the old code in place. These results are checked against a queue-based page model on every clock.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int BYTE_W = 8;
    localparam int COL_W  = 2 * $clog2(BYTE_W);
    localparam int WORD_W = 16;

    localparam logic [7:0] MODE_DATA    = 8'h94;
    localparam logic [7:0] MODE_ECC_CLR = 8'hF4;
    localparam logic [7:0] MODE_ECC_RUN = 8'hB4;
    localparam logic [7:0] MODE_ECC_OUT = 8'hD4;

    typedef enum logic [1:0] {
        ST_DATA,
        ST_CLR_WAIT,
        ST_CALC,
        ST_RESULT
    } ecc_state_e;

    // Mask of bit positions whose position number has bit k set (k selects pair)
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int HALF_BYTES = 256
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             mode_wr,
    input  logic [7:0]                       mode_code,
    input  logic                             byte_valid,
    input  logic                             rd_strobe,
    output ecc_state_e                       state_o,
    output logic                             clr_o,
    output logic [1:0]                       acc_en_o,
    output logic [$clog2(HALF_BYTES)-1:0]    idx_o,
    output logic [1:0]                       rsel_o
);
    localparam int IDX_W = $clog2(HALF_BYTES);
    localparam int CNT_W = IDX_W + 2;
    localparam int LIMIT = 2 * HALF_BYTES;

    ecc_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [1:0]         rsel_q;
    logic               full;

    assign full = cnt_q[CNT_W-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DATA;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            case (mode_code)
                MODE_ECC_CLR: state_d = ST_CLR_WAIT;
                MODE_ECC_RUN: state_d = ST_CALC;
                MODE_ECC_OUT: state_d = ST_RESULT;
                MODE_DATA:    state_d = ST_DATA;
                default:      state_d = state_q;
            endcase
        end
    end

    // outputs decoded from the current state
    always_comb begin
        clr_o    = 1'b0;
        acc_en_o = 2'b00;
        unique case (state_q)
            ST_DATA:     ;
            ST_CLR_WAIT: clr_o = rd_strobe;
            ST_CALC:     if (byte_valid && !full) acc_en_o[cnt_q[IDX_W]] = 1'b1;
            ST_RESULT:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr_o)       cnt_q <= '0;
        else if (|acc_en_o)   cnt_q <= cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsel_q <= 2'd0;
        else if (mode_wr && mode_code == MODE_ECC_OUT)
            rsel_q <= 2'd0;
        else if (state_q == ST_RESULT && rd_strobe)
            rsel_q <= (rsel_q == 2'd2) ? 2'd0 : rsel_q + 2'd1;
    end

    assign state_o = state_q;
    assign idx_o   = cnt_q[IDX_W-1:0];
    assign rsel_o  = rsel_q;

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= LIMIT);

    // R6
    half_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en_o[0] |-> int'(cnt_q) < HALF_BYTES);

    // R8
    rsel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsel_q != 2'd3);

    // R9
    data_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_code == MODE_DATA) |=> state_q == ST_DATA);

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [BYTE_W-1:0]     data,
    output logic [2*IDX_W-1:0]    lp_o,
    output logic [COL_W-1:0]      cp_o
);
    localparam int LP_W   = 2 * IDX_W;
    localparam int PAIR_N = COL_W / 2;

    logic [LP_W-1:0]  lp_q, lp_tog;
    logic [COL_W-1:0] cp_q, cp_tog;
    logic             weight_odd;

    assign weight_odd = ^data;

    generate
        for (genvar k = 0; k < IDX_W; k++) begin : g_line
            assign lp_tog[2*k+1] = weight_odd &  idx[k];
            assign lp_tog[2*k]   = weight_odd & ~idx[k];
        end
        for (genvar k = 0; k < PAIR_N; k++) begin : g_col
            localparam logic [BYTE_W-1:0] MASK = col_mask(k);
            assign cp_tog[2*k+1] = ^(data &  MASK);
            assign cp_tog[2*k]   = ^(data & ~MASK);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lp_q <= '0;
            cp_q <= '0;
        end else if (en) begin
            lp_q <= lp_q ^ lp_tog;
            cp_q <= cp_q ^ cp_tog;
        end
    end

    assign lp_o = lp_q;
    assign cp_o = cp_q;

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lp_q == '0 && cp_q == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> ($stable(lp_q) && $stable(cp_q)));

    // R4
    even_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en && $countones(data) % 2 == 0) |=> $stable(lp_q));

endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
    import nand_ecc_pkg::*;
#(
    parameter int LP_W = 16
) (
    input  ecc_state_e          state_i,
    input  logic [1:0]          rsel_i,
    input  logic [LP_W-1:0]     lp0_i,
    input  logic [COL_W-1:0]    cp0_i,
    input  logic [LP_W-1:0]     lp1_i,
    input  logic [COL_W-1:0]    cp1_i,
    output logic [WORD_W-1:0]   rd_data_o
);
    logic [7:0] code0, code1;

    assign code0 = {cp0_i, 2'b11};
    assign code1 = {cp1_i, 2'b11};

    always_comb begin
        rd_data_o = '0;
        if (state_i == ST_RESULT) begin
            unique case (rsel_i)
                2'd0:    rd_data_o = {lp0_i[7:0], lp0_i[15:8]};
                2'd1:    rd_data_o = {lp1_i[7:0], code0};
                2'd2:    rd_data_o = {code1, lp1_i[15:8]};
                default: rd_data_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int HALF_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [7:0]  mode_code,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic        rd_strobe,
    output logic [15:0] rd_data
);
    localparam int IDX_W = $clog2(HALF_BYTES);
    localparam int LP_W  = 2 * IDX_W;

    ecc_state_e         state;
    logic               clr;
    logic [1:0]         acc_en, rsel;
    logic [IDX_W-1:0]   idx;
    logic [LP_W-1:0]    lp [2];
    logic [COL_W-1:0]   cp [2];

    nand_ecc_ctrl #(.HALF_BYTES(HALF_BYTES)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_code  (mode_code),
        .byte_valid (byte_valid),
        .rd_strobe  (rd_strobe),
        .state_o    (state),
        .clr_o      (clr),
        .acc_en_o   (acc_en),
        .idx_o      (idx),
        .rsel_o     (rsel)
    );

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            nand_ecc_accum #(.IDX_W(IDX_W)) i_accum (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .en    (acc_en[h]),
                .idx   (idx),
                .data  (byte_in),
                .lp_o  (lp[h]),
                .cp_o  (cp[h])
            );
        end
    endgenerate

    nand_ecc_readout #(.LP_W(LP_W)) i_readout (
        .state_i   (state),
        .rsel_i    (rsel),
        .lp0_i     (lp[0]),
        .cp0_i     (cp[0]),
        .lp1_i     (lp[1]),
        .cp1_i     (cp[1]),
        .rd_data_o (rd_data)
    );

    // R8
    rd_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESULT && rsel == 2'd1) |-> rd_data[1:0] == 2'b11);

endmodule

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_code = 8'h00;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit run_cmp = 1'b0;

    always #2.5 clk = ~clk;

    nand_ecc_gen i_nand_ecc_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_code  (mode_code),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .rd_strobe  (rd_strobe),
        .rd_data    (rd_data)
    );

    // ---------------- behavioural reference: 0 data, 1 clear-wait, 2 calc, 3 result
    int  mst = 0;
    int  mptr = 0;
    byte unsigned page_q[$];

    always @(posedge clk) begin
        int nst;
        if (!rst_n) begin
            mst = 0; mptr = 0; page_q.delete();
        end else begin
            nst = mst;
            if (mst == 1 && rd_strobe) page_q.delete();
            if (mst == 2 && byte_valid && page_q.size() < 512) page_q.push_back(byte_in);
            if (mst == 3 && rd_strobe) mptr = (mptr + 1) % 3;
            if (mode_wr) begin
                case (mode_code)
                    8'hF4: nst = 1;
                    8'hB4: nst = 2;
                    8'hD4: begin nst = 3; mptr = 0; end
                    8'h94: nst = 0;
                    default: ;
                endcase
            end
            mst = nst;
        end
    end

    function automatic logic [15:0] model_word();
        int lp [2];
        int cp [2];
        logic [7:0] cb [2];
        lp[0] = 0; lp[1] = 0; cp[0] = 0; cp[1] = 0;
        if (mst != 3) return 16'h0000;
        for (int j = 0; j < page_q.size(); j++) begin
            int h = j / 256;
            int ix = j % 256;
            for (int b = 0; b < 8; b++) begin
                if (page_q[j][b]) begin
                    for (int k = 0; k < 3; k++) cp[h] ^= 1 << (2*k + ((b >> k) & 1));
                    for (int k = 0; k < 8; k++) lp[h] ^= 1 << (2*k + ((ix >> k) & 1));
                end
            end
        end
        cb[0] = 8'((cp[0] << 2) | 3);
        cb[1] = 8'((cp[1] << 2) | 3);
        case (mptr)
            0: return {lp[0][7:0], lp[0][15:8]};
            1: return {lp[1][7:0], cb[0]};
            default: return {cb[1], lp[1][15:8]};
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R8 every-cycle comparison against the page model
    always @(negedge clk) begin
        if (run_cmp) check("R8 per-cycle model", rd_data, model_word());
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic set_mode(input logic [7:0] c);
        mode_wr = 1'b1; mode_code = c;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        byte_valid = 1'b1; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [15:0] exp);
        check(tag, rd_data, exp);
        do_read();
    endtask

    task automatic clear_and_run();
        set_mode(8'hF4);
        do_read();
        set_mode(8'hB4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 16'h0000);
        run_cmp = 1'b1;

        // R2: empty page after clear
        clear_and_run();
        set_mode(8'hD4);
        read_check("R2 empty word0", 16'h0000);
        read_check("R2 empty word1", 16'h0003);
        read_check("R2 empty word2", 16'h0300);

        // R4 / R5: single byte 0x01 at index 0
        clear_and_run();
        push(8'h01);
        set_mode(8'hD4);
        read_check("R4 line parity word0", 16'h5555);
        read_check("R5 column parity word1", 16'h0057);
        read_check("R5 empty second half word2", 16'h0300);
        read_check("R8 wrap to word0", 16'h5555);
        // R9: unknown code ignored, then data mode
        set_mode(8'h12);
        check("R9 unknown code ignored", rd_data, 16'h0057);
        set_mode(8'h94);
        check("R9 data mode output", rd_data, 16'h0000);

        // R6: 256 zeros then 0x80 lands in the second half; R2 clear of old values
        clear_and_run();
        for (int i = 0; i < 256; i++) push(8'h00);
        push(8'h80);
        set_mode(8'hD4);
        read_check("R2 R6 first half cleared", 16'h0000);
        read_check("R6 second half line parity", 16'h5503);
        read_check("R6 second half column parity", 16'hAB55);

        // R3: bytes offered outside ST_CALC are ignored
        push(8'hFF);
        set_mode(8'h94);
        push(8'h7F); push(8'h01);
        set_mode(8'hD4);
        read_check("R3 ignored word0", 16'h0000);
        read_check("R3 ignored word1", 16'h5503);
        read_check("R3 ignored word2", 16'hAB55);

        // R10: clear mode without dummy read keeps old state
        set_mode(8'hF4);
        set_mode(8'hB4);
        push(8'h01);
        set_mode(8'hD4);
        read_check("R10 kept word0", 16'h0000);
        read_check("R10 kept word1", 16'h0303);
        read_check("R10 kept word2", 16'hFF00);

        // R7: 600 bytes, only the first 512 count
        clear_and_run();
        for (int i = 0; i < 600; i++) push(8'((i * 7 + 3) & 255));
        set_mode(8'hD4);
        for (int w = 0; w < 3; w++) read_check("R7 overflow ignored", model_word());
        // R7 extra bytes after full stay ignored on re-entry
        set_mode(8'hB4);
        push(8'hA5);
        set_mode(8'hD4);
        read_check("R7 full page word0", model_word());
        set_mode(8'h94);

        run_cmp = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule